// File: doc/BRIEF.md
# PWM-Input Synchronous Rectification Controller

This block turns an active-low speed-command pulse train into two mutually exclusive enables for one leg of a three-phase bridge: a low-side switching enable and a high-side synchronous-rectification enable. It inserts a selectable dead time between them. The command input is synchronized by two flops. A free-running set of counters measures how long the input stays high, how long it stays low and how long each period lasts.

Those measurements decide when synchronous rectification is withheld. A fan policy drops it on zero duty, low input frequency, very short on-times or reverse current. An office-equipment policy keeps it on in all of these cases and asks for a short brake when the duty reaches zero. A current-limit comparator can end an on-time early. It is ignored for a blanking interval after each low-side turn-on, and once it trips it holds the low side off until the next tick of an internal reference counter.

Top module: `pwm_sr_ctrl`

## Requirements
- R1: While reset is asserted, `ls_en`, `sr_en`, `duty_zero` and `brake_req` are all 0.
- R2: The command is active low. Once synchronized, a low level requests the low side and a high level releases it. `ls_en` follows the request after the two synchronizer flops, plus any dead time still owed.
- R3: `ls_en` and `sr_en` are never 1 together. Each rising edge of either one comes after exactly the selected number of cycles with both at 0. `dt_sel` = 0, 1, 2, 3 selects `DT_C0`, `DT_C1`, `DT_C2`, `DT_C3` cycles.
- R4: `duty_zero` rises after the synchronized command has been high for `ZERO_CYC` cycles. It clears as soon as the command goes low again.
- R5: With `duty_zero` set and `fan_mode` = 1, `sr_en` is 0 and `brake_req` is 0 (freewheel). With `fan_mode` = 0, `brake_req` is 1 and `sr_en` is 0.
- R6: When the measured command period is at least `LOWF_CYC` cycles, `fan_mode` = 1 keeps `sr_en` at 0. `fan_mode` = 0 still raises `sr_en` during off-time.
- R7: When the last low pulse was shorter than `MIN_ON_CYC` cycles, `fan_mode` = 1 keeps `sr_en` at 0. `fan_mode` = 0 still raises `sr_en`. With a normal period and duty, `sr_en` rises during off-time in both modes.
- R8: In `fan_mode` = 1, `sr_en` is 0 while `rev_cur` is 1 and returns once it clears. In `fan_mode` = 0, `rev_cur` has no effect on `sr_en`.
- R9: `ilim_trip` is ignored for the first `BLANK_CYC` cycles of every low-side on-time. With the comparator held at 1, each low-side pulse lasts exactly `BLANK_CYC`+1 cycles.
- R10: A trip ends the on-time and keeps `ls_en` at 0 until the next reference tick. Ticks occur every `CHOP_CYC` cycles, so under a held trip and a held command, successive low-side turn-ons are exactly `CHOP_CYC` cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_in_n | input | 1 | Speed command pulse train, active low, asynchronous |
| dt_sel | input | 2 | Dead-time code |
| fan_mode | input | 1 | 1 = fan policy, 0 = office-equipment policy |
| ilim_trip | input | 1 | Current-limit comparator output |
| rev_cur | input | 1 | Reverse-current detected |
| ls_en | output | 1 | Low-side switching enable |
| sr_en | output | 1 | High-side synchronous-rectification enable |
| duty_zero | output | 1 | Zero duty detected |
| brake_req | output | 1 | Short-brake request |

## Verification
The current-limit trip and the dead-time sequencer can act in the same cycle. A trip ends the on-time and starts the dead count toward rectification, and a later reference tick takes rectification back away. The bench holds the comparator high under a continuous command in office mode. It expects pulses of exactly `BLANK_CYC`+1 cycles whose rising edges sit exactly `CHOP_CYC` apart, while a scoreboard separately checks each dead gap against the selected code.

// File: rtl/pwm_sr_ctrl.sv
module pwm_sr_ctrl #(
  parameter int DT_C0      = 250,
  parameter int DT_C1      = 188,
  parameter int DT_C2      = 125,
  parameter int DT_C3      = 63,
  parameter int ZERO_CYC   = 312500,
  parameter int LOWF_CYC   = 16667,
  parameter int MIN_ON_CYC = 188,
  parameter int BLANK_CYC  = 188,
  parameter int CHOP_CYC   = 2500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_in_n,
  input  logic [1:0] dt_sel,
  input  logic       fan_mode,
  input  logic       ilim_trip,
  input  logic       rev_cur,
  output logic       ls_en,
  output logic       sr_en,
  output logic       duty_zero,
  output logic       brake_req
);

  localparam int D01  = (DT_C0 > DT_C1) ? DT_C0 : DT_C1;
  localparam int D23  = (DT_C2 > DT_C3) ? DT_C2 : DT_C3;
  localparam int DMAX = (D01 > D23) ? D01 : D23;
  localparam int DW = $clog2(DMAX + 1);
  localparam int ZW = $clog2(ZERO_CYC + 1);
  localparam int PW = $clog2(LOWF_CYC + 1);
  localparam int OW = $clog2(MIN_ON_CYC + 1);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int KW = $clog2(CHOP_CYC);
  localparam logic [ZW-1:0] ZERO_V  = ZW'(ZERO_CYC);
  localparam logic [PW-1:0] LOWF_V  = PW'(LOWF_CYC);
  localparam logic [OW-1:0] MINON_V = OW'(MIN_ON_CYC);
  localparam logic [BW-1:0] BLANK_V = BW'(BLANK_CYC);
  localparam logic [KW-1:0] KLAST_V = KW'(CHOP_CYC - 1);
  localparam logic [DW-1:0] DMAX_V  = DW'(DMAX);

  logic [2:0]    sy;
  logic [ZW-1:0] hi_cnt;
  logic [PW-1:0] per_cnt;
  logic [OW-1:0] on_cnt;
  logic [BW-1:0] blk_cnt;
  logic [KW-1:0] ref_cnt;
  logic [DW-1:0] dt_cnt, dt_lim;
  logic          low_freq, low_duty, ilim_hold;

  wire cmd_hi   = sy[1];
  wire fall     = sy[2] & ~sy[1];
  wire rise     = ~sy[2] & sy[1];
  wire tick     = (ref_cnt == KLAST_V);
  wire trip_now = ls_en & (blk_cnt == BLANK_V) & ilim_trip;
  wire ls_req   = ~cmd_hi & ~ilim_hold & ~trip_now;
  wire sr_blk   = duty_zero | (fan_mode & (low_freq | low_duty | rev_cur));
  wire sr_req   = ~ls_req & ~sr_blk;
  wire dead_ok  = (dt_cnt >= dt_lim - DW'(1));

  assign duty_zero = (hi_cnt == ZERO_V);
  assign brake_req = duty_zero & ~fan_mode;

  always_comb
    case (dt_sel)
      2'd0:    dt_lim = DW'(DT_C0);
      2'd1:    dt_lim = DW'(DT_C1);
      2'd2:    dt_lim = DW'(DT_C2);
      default: dt_lim = DW'(DT_C3);
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy <= 3'b111;
    else        sy <= {sy[1:0], pwm_in_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_cnt   <= '0;
      per_cnt  <= '0;
      on_cnt   <= '0;
      low_freq <= 1'b1;
      low_duty <= 1'b1;
    end else begin
      if (!cmd_hi)               hi_cnt <= '0;
      else if (hi_cnt != ZERO_V) hi_cnt <= hi_cnt + 1'b1;

      if (fall)                   per_cnt <= PW'(1);
      else if (per_cnt != LOWF_V) per_cnt <= per_cnt + 1'b1;

      if (fall)                   low_freq <= (per_cnt >= LOWF_V);
      else if (per_cnt == LOWF_V) low_freq <= 1'b1;

      if (cmd_hi)                 on_cnt <= '0;
      else if (on_cnt != MINON_V) on_cnt <= on_cnt + 1'b1;

      if (rise) low_duty <= (on_cnt < MINON_V);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_cnt   <= '0;
      blk_cnt   <= '0;
      ilim_hold <= 1'b0;
    end else begin
      ref_cnt <= tick ? '0 : ref_cnt + 1'b1;
      if (!ls_en)                  blk_cnt <= '0;
      else if (blk_cnt != BLANK_V) blk_cnt <= blk_cnt + 1'b1;
      if (tick)          ilim_hold <= 1'b0;
      else if (trip_now) ilim_hold <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ls_en  <= 1'b0;
      sr_en  <= 1'b0;
      dt_cnt <= '0;
    end else if (ls_en && !ls_req) begin
      ls_en  <= 1'b0;
      dt_cnt <= '0;
    end else if (sr_en && !sr_req) begin
      sr_en  <= 1'b0;
      dt_cnt <= '0;
    end else if (!ls_en && !sr_en) begin
      if (ls_req && dead_ok)      ls_en <= 1'b1;
      else if (sr_req && dead_ok) sr_en <= 1'b1;
      if (dt_cnt != DMAX_V) dt_cnt <= dt_cnt + 1'b1;
    end

endmodule

// File: rtl/pwm_sr_ctrl_chk.sv
module pwm_sr_ctrl_chk #(
  parameter int DT_C0 = 250,
  parameter int DT_C1 = 188,
  parameter int DT_C2 = 125,
  parameter int DT_C3 = 63
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] dt_sel,
  input logic       fan_mode,
  input logic       rev_cur,
  input logic       ls_en,
  input logic       sr_en,
  input logic       duty_zero,
  input logic       brake_req
);

  localparam int D01  = (DT_C0 > DT_C1) ? DT_C0 : DT_C1;
  localparam int D23  = (DT_C2 > DT_C3) ? DT_C2 : DT_C3;
  localparam int DMAX = (D01 > D23) ? D01 : D23;
  localparam int GW   = $clog2(DMAX + 2);

  logic [GW-1:0] gap, lim;

  always_comb
    case (dt_sel)
      2'd0:    lim = GW'(DT_C0);
      2'd1:    lim = GW'(DT_C1);
      2'd2:    lim = GW'(DT_C2);
      default: lim = GW'(DT_C3);
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                gap <= '0;
    else if (ls_en || sr_en)   gap <= '0;
    else if (gap != '1)        gap <= gap + 1'b1;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(ls_en && sr_en)); // R3
  AST_LS_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> gap >= $past(lim)); // R3
  AST_SR_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_en) |-> gap >= $past(lim)); // R3
  AST_ZERO_NO_SR: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_zero && $past(duty_zero)) |-> !sr_en); // R5
  AST_BRAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (brake_req && $past(brake_req)) |-> (!ls_en && !sr_en)); // R5
  AST_FAN_REV_NO_SR: assert property (@(posedge clk) disable iff (!rst_n)
    (fan_mode && rev_cur && $past(fan_mode && rev_cur)) |-> !sr_en); // R8

endmodule

bind pwm_sr_ctrl pwm_sr_ctrl_chk #(
  .DT_C0(DT_C0), .DT_C1(DT_C1), .DT_C2(DT_C2), .DT_C3(DT_C3)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dt_sel(dt_sel), .fan_mode(fan_mode),
  .rev_cur(rev_cur), .ls_en(ls_en), .sr_en(sr_en),
  .duty_zero(duty_zero), .brake_req(brake_req)
);

// File: tb/pwm_sr_ctrl_test.sv
module pwm_sr_ctrl_test;
  localparam int D0 = 8, D1 = 6, D2 = 4, D3 = 2;
  localparam int ZERO = 400, LOWF = 200, MINON = 10, BLANK = 6, CHOP = 300;

  logic clk = 1'b0, rst_n = 1'b0, pwm_in_n = 1'b1, fan_mode = 1'b0;
  logic ilim_trip = 1'b0, rev_cur = 1'b0;
  logic [1:0] dt_sel = 2'd0;
  logic ls_en, sr_en, duty_zero, brake_req;

  int nchk = 0, nerr = 0;
  int sr_seen = 0, ls_seen = 0;
  int exp_q[$];
  int pl = 0, ps = 0, gap = 0, who = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_sr_ctrl #(.DT_C0(D0), .DT_C1(D1), .DT_C2(D2), .DT_C3(D3),
    .ZERO_CYC(ZERO), .LOWF_CYC(LOWF), .MIN_ON_CYC(MINON),
    .BLANK_CYC(BLANK), .CHOP_CYC(CHOP)) uut (
    .clk(clk), .rst_n(rst_n), .pwm_in_n(pwm_in_n), .dt_sel(dt_sel),
    .fan_mode(fan_mode), .ilim_trip(ilim_trip), .rev_cur(rev_cur),
    .ls_en(ls_en), .sr_en(sr_en), .duty_zero(duty_zero), .brake_req(brake_req));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: counts both-off cycles of each hand-over and pops the expected gap
  always @(negedge clk) begin
    if (!rst_n) begin
      pl = 0; ps = 0; gap = 0; who = 0;
    end else begin
      if (!ls_en && !sr_en) gap++;
      else begin
        if (((ls_en && pl == 0 && who == 2) || (sr_en && ps == 0 && who == 1))
            && exp_q.size() > 0) begin
          int e;
          e = exp_q.pop_front();
          chk(gap == e, "R3 dead gap", gap, e);
        end
        gap = 0;
      end
      if (pl == 1 && !ls_en) who = 1;
      if (ps == 1 && !sr_en) who = 2;
      pl = ls_en; ps = sr_en;
    end
  end

  task automatic run_pwm(input int period, input int on, input int n);
    for (int p = 0; p < n; p++)
      for (int c = 0; c < period; c++) begin
        pwm_in_n = (c < on) ? 1'b0 : 1'b1;
        @(negedge clk);
        if (sr_en) sr_seen++;
        if (ls_en) ls_seen++;
      end
  endtask

  task automatic measure_sr(input int period, input int on, input bit expect_on, input string req);
    run_pwm(period, on, 4);
    sr_seen = 0; ls_seen = 0;
    run_pwm(period, on, 3);
    if (expect_on) chk(sr_seen > 0, req, sr_seen, 1);
    else           chk(sr_seen == 0, req, sr_seen, 0);
  endtask

  initial begin
    int dts[4];
    int rise_t[4];
    int nr, plen, got_fall, prv;
    dts = '{D0, D1, D2, D3};
    repeat (5) @(negedge clk);
    chk(!ls_en && !sr_en && !duty_zero && !brake_req, "R1 reset outputs",
        {ls_en, sr_en, duty_zero, brake_req}, 0);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);

    // R2: low command turns low side on, high turns it off
    pwm_in_n = 1'b0;
    repeat (14) @(negedge clk);
    chk(ls_en && !sr_en, "R2 low command on", {ls_en, sr_en}, 2);
    pwm_in_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!ls_en, "R2 high command off", ls_en, 0);

    // R3: every dead-time code, office policy
    for (int s = 0; s < 4; s++) begin
      dt_sel = 2'(s);
      run_pwm(100, 40, 2);
      for (int k = 0; k < 4; k++) exp_q.push_back(dts[s]);
      run_pwm(100, 40, 3);
      chk(exp_q.size() == 0, "R3 gaps observed", exp_q.size(), 0);
      exp_q.delete();
    end

    // R4 / R5: zero duty
    dt_sel = 2'd0;
    pwm_in_n = 1'b0;
    repeat (20) @(negedge clk);
    pwm_in_n = 1'b1;
    repeat (ZERO - 10) @(negedge clk);
    chk(!duty_zero, "R4 not yet zero", duty_zero, 0);
    repeat (20) @(negedge clk);
    chk(duty_zero, "R4 zero detected", duty_zero, 1);
    chk(brake_req && !sr_en, "R5 office brake", {brake_req, sr_en}, 2);
    fan_mode = 1'b1;
    repeat (2) @(negedge clk);
    chk(!brake_req && !sr_en, "R5 fan freewheel", {brake_req, sr_en}, 0);
    pwm_in_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(!duty_zero, "R4 zero cleared", duty_zero, 0);

    // R7: normal duty gives rectification in fan mode; R6 low frequency
    dt_sel = 2'd3;
    measure_sr(100, 40, 1'b1, "R7 fan normal rectifies");
    measure_sr(300, 100, 1'b0, "R6 fan low freq blocks");
    fan_mode = 1'b0;
    measure_sr(300, 100, 1'b1, "R6 office low freq keeps");

    // R7: very short on-time
    fan_mode = 1'b1;
    measure_sr(100, 5, 1'b0, "R7 fan low duty blocks");
    chk(ls_seen > 0, "R7 short pulses still drive", ls_seen, 1);
    fan_mode = 1'b0;
    measure_sr(100, 5, 1'b1, "R7 office low duty keeps");

    // R8: reverse current
    fan_mode = 1'b1;
    rev_cur = 1'b1;
    measure_sr(100, 40, 1'b0, "R8 fan reverse blocks");
    rev_cur = 1'b0;
    measure_sr(100, 40, 1'b1, "R8 fan reverse released");
    fan_mode = 1'b0;
    rev_cur = 1'b1;
    measure_sr(100, 40, 1'b1, "R8 office ignores reverse");
    rev_cur = 1'b0;

    // R9 / R10: held comparator, held command
    pwm_in_n = 1'b1;
    repeat (20) @(negedge clk);
    ilim_trip = 1'b1;
    pwm_in_n = 1'b0;
    nr = 0; plen = 0; got_fall = 0; prv = ls_en;
    for (int c = 0; c < 1300; c++) begin
      @(negedge clk);
      if (ls_en && prv == 0) begin
        if (nr < 4) rise_t[nr] = c;
        nr++;
      end
      if (!ls_en && prv == 1 && got_fall == 0) begin
        plen = c - rise_t[0];
        got_fall = 1;
      end
      prv = ls_en;
    end
    chk(plen == BLANK + 1, "R9 blanked pulse width", plen, BLANK + 1);
    chk(nr >= 3, "R10 re-armed pulses", nr, 3);
    if (nr >= 3) chk(rise_t[2] - rise_t[1] == CHOP, "R10 re-arm spacing",
                     rise_t[2] - rise_t[1], CHOP);
    ilim_trip = 1'b0;
    pwm_in_n = 1'b1;
    repeat (10) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule